// File: doc/BRIEF.md
# Super-cycle dithered PWM generator

This block produces a single-bit pulse-width signal with a resolution of BASE_W + EXT_W bits. A long frame, the super-cycle, is made of 2^EXT_W short base cycles, and each base cycle is 2^BASE_W clock states long. The frequency content that matters most for the downstream low-pass filter therefore sits at the base-cycle rate and not at the full-frame rate. The duty word has two parts: a base count S of BASE_W bits and an extra count X of EXT_W bits. Every base cycle opens with S high states. In X of the base cycles, one more high state is appended directly after those S states. A modular rule chooses these cycles so that they are spread evenly over the super-cycle.

The duty word is sampled once per super-cycle, on the clock edge that starts a new super-cycle. A frame therefore never mixes old and new duty values, and the average duty over a frame is (2^EXT_W·S + X) / 2^(BASE_W+EXT_W). The output is registered. It stays low through reset and changes first on the first clock edge after reset is released, which is also the edge where the first duty word is sampled.

Top module: `scpwm_gen`

## Requirements
- R1: While rst_n is low, pwm_o is low. The first rising clock edge with rst_n high samples the duty inputs, and pwm_o then shows state 0 of base cycle 0.
- R2: A base cycle lasts 2^BASE_W clocks. States 0 to S-1 (counted from the first clock of the base cycle) are high.
- R3: In a base cycle that receives the extra state, state S is high. In any other base cycle, state S is low.
- R4: Base cycle c (0 to 2^EXT_W-1, counted from the super-cycle start) receives the extra state exactly when ((c·X) mod 2^EXT_W) > (2^EXT_W − 1 − X). Each base cycle therefore holds S or S+1 high states.
- R5: Over one super-cycle, pwm_o is high for exactly 2^EXT_W·S + X clocks.
- R6: When X = 0, no base cycle receives an extra state. When S = 0 and X = 0, pwm_o stays low for the whole super-cycle.
- R7: S and X are sampled only at super-cycle boundaries. A change of duty_base_i or duty_ext_i in the middle of a super-cycle has no effect on pwm_o until the next super-cycle begins.
- R8: With EXT_W = 1, BASE_W = 8, S = 60 and X = 1, base cycle 0 holds 60 high states and base cycle 1 holds 61.
- R9: With S = 2^BASE_W − 1, a base cycle that receives the extra state is high for all of its 2^BASE_W clocks.
- R10: Within a base cycle, the high states form one contiguous run that starts at state 0. Once pwm_o falls, it stays low until the base cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_base_i | input | BASE_W | Base count S: high states at the start of every base cycle |
| duty_ext_i | input | EXT_W | Extra count X: number of base cycles per super-cycle that get one more high state |
| pwm_o | output | 1 | Registered pulse-width output |

## Verification
The case that needs care is a new duty word arriving on the last state of a super-cycle. On that edge the sampling of the duty word and the rollover of both counters happen together. A decode that used the old duty word for state 0 of the new frame would be off by one cycle. The bench waits until its reference model reaches that final state, then changes the inputs so that they are captured on the very next edge. It compares pwm_o against the model at every clock and checks the high-state count of the frame that follows. Mid-frame duty changes are applied as well. For these, the frame count must still match the word that was sampled at the frame start.

// File: rtl/scpwm_pkg.sv
package scpwm_pkg;

    localparam int unsigned SCP_BASE_W_DEF = 8;
    localparam int unsigned SCP_EXT_W_DEF  = 4;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } scp_phase_e;

endpackage

// File: rtl/scpwm_timebase.sv
module scpwm_timebase #(
    parameter int unsigned BASE_W = 8,
    parameter int unsigned EXT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    output logic [BASE_W-1:0] slot_q_o,
    output logic [BASE_W-1:0] slot_nx_o,
    output logic [EXT_W-1:0]  cyc_nx_o,
    output logic              super_end_o
);

    localparam logic [BASE_W-1:0] SLOT_LAST = '1;
    localparam logic [EXT_W-1:0]  CYC_LAST  = '1;
    localparam logic [BASE_W-1:0] SLOT_STEP = BASE_W'(1);
    localparam logic [EXT_W-1:0]  CYC_STEP  = EXT_W'(1);

    typedef struct packed {
        logic [BASE_W-1:0] slot;
        logic [EXT_W-1:0]  cyc;
    } tb_state_t;

    tb_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (adv_i) begin
            cnt_d.slot = cnt_q.slot + SLOT_STEP;
            if (cnt_q.slot == SLOT_LAST) begin
                cnt_d.cyc = cnt_q.cyc + CYC_STEP;
            end
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign slot_q_o    = cnt_q.slot;
    assign slot_nx_o   = cnt_d.slot;
    assign cyc_nx_o    = cnt_d.cyc;
    assign super_end_o = adv_i && (cnt_q.slot == SLOT_LAST) && (cnt_q.cyc == CYC_LAST);

    // Base cycle length is 2^BASE_W: the slot counter returns to zero after its last value.
    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && cnt_q.slot == SLOT_LAST) |=> (cnt_q.slot == '0));

    // The cycle index moves only at a base-cycle boundary.
    assert_cyc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && cnt_q.slot != SLOT_LAST) |=> $stable(cnt_q.cyc));

endmodule

// File: rtl/scpwm_duty_latch.sv
module scpwm_duty_latch #(
    parameter int unsigned BASE_W = 8,
    parameter int unsigned EXT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [EXT_W-1:0]  ext_i,
    output logic [BASE_W-1:0] base_q_o,
    output logic [EXT_W-1:0]  ext_q_o,
    output logic [BASE_W-1:0] base_nx_o,
    output logic [EXT_W-1:0]  ext_nx_o
);

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [EXT_W-1:0]  ext;
    } duty_t;

    duty_t duty_d, duty_q;

    always_comb begin
        duty_d = duty_q;
        if (load_i) begin
            duty_d.base = base_i;
            duty_d.ext  = ext_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else begin
            duty_q <= duty_d;
        end
    end

    assign base_q_o  = duty_q.base;
    assign ext_q_o   = duty_q.ext;
    assign base_nx_o = duty_d.base;
    assign ext_nx_o  = duty_d.ext;

    // The held duty word changes only on a super-cycle boundary.
    assert_duty_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(duty_q.base) && $stable(duty_q.ext)));

endmodule

// File: rtl/scpwm_extra_pick.sv
module scpwm_extra_pick #(
    parameter int unsigned EXT_W = 4
) (
    input  logic [EXT_W-1:0] cyc_i,
    input  logic [EXT_W-1:0] ext_i,
    output logic             hit_o
);

    localparam logic [EXT_W-1:0] FULL_MASK = '1;

    generate
        if (EXT_W == 1) begin : g_pair
            // Two cycles only: the single extra state always lands in cycle 1.
            assign hit_o = cyc_i[0] & ext_i[0];
        end else begin : g_spread
            logic [EXT_W-1:0] phase_acc;
            logic [EXT_W-1:0] limit;
            assign phase_acc = cyc_i * ext_i;
            assign limit     = FULL_MASK - ext_i;
            assign hit_o     = (phase_acc > limit);
        end
    endgenerate

endmodule

// File: rtl/scpwm_gen.sv
module scpwm_gen #(
    parameter int unsigned BASE_W = scpwm_pkg::SCP_BASE_W_DEF,
    parameter int unsigned EXT_W  = scpwm_pkg::SCP_EXT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] duty_base_i,
    input  logic [EXT_W-1:0]  duty_ext_i,
    output logic              pwm_o
);

    import scpwm_pkg::*;

    localparam logic [BASE_W-1:0] SLOT_LAST = '1;

    typedef struct packed {
        scp_phase_e phase;
        logic       pwm;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              run;
    logic              load;
    logic              super_end;
    logic [BASE_W-1:0] slot_q, slot_nx;
    logic [EXT_W-1:0]  cyc_nx;
    logic [BASE_W-1:0] base_q, base_nx;
    logic [EXT_W-1:0]  ext_q, ext_nx;
    logic              hit_nx;

    assign run  = (st_q.phase == PH_RUN);
    assign load = !run || super_end;

    scpwm_timebase #(.BASE_W(BASE_W), .EXT_W(EXT_W)) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (run),
        .slot_q_o    (slot_q),
        .slot_nx_o   (slot_nx),
        .cyc_nx_o    (cyc_nx),
        .super_end_o (super_end)
    );

    scpwm_duty_latch #(.BASE_W(BASE_W), .EXT_W(EXT_W)) u_duty (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .base_i    (duty_base_i),
        .ext_i     (duty_ext_i),
        .base_q_o  (base_q),
        .ext_q_o   (ext_q),
        .base_nx_o (base_nx),
        .ext_nx_o  (ext_nx)
    );

    scpwm_extra_pick #(.EXT_W(EXT_W)) u_pick (
        .cyc_i (cyc_nx),
        .ext_i (ext_nx),
        .hit_o (hit_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.phase = PH_RUN;
        st_d.pwm   = (slot_nx < base_nx) || ((slot_nx == base_nx) && hit_nx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, pwm: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.pwm;

    // Before the first running cycle the output is low.
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !st_q.pwm);

    // Once low inside a base cycle, the output stays low until the cycle ends.
    assert_single_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !st_q.pwm && slot_q != SLOT_LAST) |=> !st_q.pwm);

    // A nonzero base count makes the first state of the next base cycle high (same frame).
    assert_cycle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && base_q != '0 && slot_q == SLOT_LAST && !super_end) |=> st_q.pwm);

    // No extra state when the extra count is zero.
    assert_no_extra_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ext_q == '0 && slot_q == base_q) |-> !st_q.pwm);

endmodule

// File: tb/scpwm_gen_tb.sv
`timescale 1ns/1ps
module scpwm_gen_tb;

    localparam int BW = 8;
    localparam int EW = 4;
    localparam int NS = 1 << BW;
    localparam int NC = 1 << EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] s_in = 8'd100;
    logic [EW-1:0] x_in = 4'd5;
    logic          pwm;
    logic          pwm_half;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit mrun = 0;
    int mst = 0, mcy = 0, mS = 0, mX = 0;
    int tk = -1;
    int base_ones = 0, sup_ones = 0, half_ones = 0;

    always #2 clk = ~clk;

    scpwm_gen #(.BASE_W(BW), .EXT_W(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .duty_base_i(s_in), .duty_ext_i(x_in), .pwm_o(pwm)
    );

    scpwm_gen #(.BASE_W(8), .EXT_W(1)) u_dut_half (
        .clk(clk), .rst_n(rst_n), .duty_base_i(8'd60), .duty_ext_i(1'b1), .pwm_o(pwm_half)
    );

    function automatic bit hit_f(int cy, int x);
        return ((cy * x) % NC) > (NC - 1 - x);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: advances on every rising edge after reset release.
    always @(posedge clk) begin
        if (rst_n) begin
            tk++;
            if (!mrun) begin
                mrun = 1; mst = 0; mcy = 0; mS = int'(s_in); mX = int'(x_in);
            end else begin
                if (mst == NS - 1 && mcy == NC - 1) begin
                    mS = int'(s_in); mX = int'(x_in);
                end
                if (mst == NS - 1) begin
                    mst = 0;
                    mcy = (mcy + 1) % NC;
                end else begin
                    mst++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk(pwm == 1'b0, "R1 reset low", int'(pwm), 0);
            end else if (mrun) begin
                bit h;
                bit exp;
                h   = hit_f(mcy, mX);
                exp = (mst < mS) || (mst == mS && h);
                if (tk == 0)            chk(pwm == exp, "R1 first edge", int'(pwm), int'(exp));
                else if (mst < mS)      chk(pwm == exp, "R2", int'(pwm), int'(exp));
                else if (mst == mS)     chk(pwm == exp, "R3", int'(pwm), int'(exp));
                else                    chk(pwm == exp, "R10", int'(pwm), int'(exp));
                base_ones += int'(pwm);
                sup_ones  += int'(pwm);
                if (mst == NS - 1) begin
                    chk(base_ones == mS + int'(h), "R4 cycle count", base_ones, mS + int'(h));
                    if (mS == NS - 1 && h) chk(base_ones == NS, "R9 full cycle", base_ones, NS);
                    base_ones = 0;
                    if (mcy == NC - 1) begin
                        chk(sup_ones == NC * mS + mX, "R5 R7 frame count", sup_ones, NC * mS + mX);
                        if (mS == 0 && mX == 0) chk(sup_ones == 0, "R6 all low", sup_ones, 0);
                        sup_ones = 0;
                    end
                end
                half_ones += int'(pwm_half);
                if ((tk % 256) == 255) begin
                    int want;
                    want = (((tk / 256) % 2) == 1) ? 61 : 60;
                    chk(half_ones == want, "R8 split pair", half_ones, want);
                    half_ones = 0;
                end
            end
        end
    end

    task automatic set_duty(int s, int x);
        s_in = BW'(s);
        x_in = EW'(x);
    endtask

    task automatic wait_frame_end();
        @(negedge clk);
        while (!(mst == NS - 1 && mcy == NC - 1)) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (NS * NC + 300) @(negedge clk);
        set_duty(0, 0);      repeat (6000) @(negedge clk);   // R6, mid-frame change R7
        set_duty(255, 15);   repeat (6000) @(negedge clk);   // R9
        set_duty(0, 1);      repeat (6000) @(negedge clk);
        set_duty(37, 8);     repeat (6000) @(negedge clk);
        set_duty(255, 0);    repeat (6000) @(negedge clk);
        // Duty change on the last state of a frame: captured on the next edge (R7).
        wait_frame_end();
        set_duty(1, 15);
        repeat (NS * NC + 10) @(negedge clk);
        wait_frame_end();
        set_duty(200, 3);
        repeat (2 * NS * NC + 10) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule